// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steers a 32-bit in-order core with branch delay slots into and out of its exception handlers. When the pipeline raises an exception, it gives the block a vector number, the faulting instruction address, a flag that marks a delay-slot instruction, and the live status word. One clock later the block has done four things. It has stored a return address that depends on the exception's class and on the delay-slot flag. It has stored a copy of the status word. It has written back a status word whose delay-slot-exception bit reflects the flag. It has issued a fetch redirect to the handler, whose address is the vector number scaled by 256 and placed in either a low or a high region, chosen by a prefix bit of the status word.

A return-from-exception strobe writes the saved status word back into the status register and redirects fetch to the saved return address. A trap request never reaches a handler. Instead it raises a debug-halt pulse that carries the trap address. A vector the block does not support raises an error pulse and leaves everything else as it was. Every action completes in one registered cycle.

Top module: `exc_seq`

## Requirements
- R1: While reset is active and in the first cycle after it releases, every pulse output is 0 and the saved return address, saved status and effective-address registers are 0.
- R2: On entry the block drives `redirect_valid` for exactly one cycle, the cycle after the request. `redirect_pc` is then (vector << 8), plus 0xF000_0000 if bit 14 of `sr_cur` is 1 or plus 0 if that bit is 0.
- R3: Vectors 5 (tick), 8 (external interrupt) and 12 (system call) save the faulting PC + 4 as the return address. Vectors 2 (bus error), 6 (alignment) and 7 (illegal instruction) save the faulting PC.
- R4: When `exc_in_dslot` is 1, 4 is subtracted from the return address that R3 selects.
- R5: On entry `esr_q` takes the whole of `sr_cur`. `sr_wr_en` pulses, and `sr_wr_data` equals `sr_cur` with bit 13 replaced by `exc_in_dslot`.
- R6: `dslot_clr` pulses for one cycle after every entry and every return.
- R7: Vector 14 (trap) pulses `halt_req` with `halt_pc` equal to the faulting PC. It does not redirect, write the status register, or change `epcr_q`, `esr_q` or `eear_q`.
- R8: Vector 7 loads `eear_q` with the faulting PC. Every other vector leaves `eear_q` unchanged.
- R9: Any vector outside {2,5,6,7,8,12,14} pulses `vec_err` and changes no other output or register.
- R10: `rfe_req` pulses `sr_wr_en` with `sr_wr_data` equal to `esr_q`, and redirects fetch to `epcr_q`.
- R11: When `exc_req` and `rfe_req` are both 1 in the same cycle, the exception is served and the return is dropped.
- R12: At most one of `redirect_valid`, `halt_req` and `vec_err` is 1 in any cycle. With no request, all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request strobe |
| exc_vec | input | 5 | Exception vector number |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| sr_cur | input | 32 | Current status register |
| rfe_req | input | 1 | Return-from-exception strobe |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Fetch redirect target |
| sr_wr_en | output | 1 | Status register write pulse |
| sr_wr_data | output | 32 | Status register write value |
| dslot_clr | output | 1 | Clear pending delay-slot state |
| epcr_q | output | 32 | Saved return address |
| esr_q | output | 32 | Saved status word |
| eear_q | output | 32 | Effective-address register |
| halt_req | output | 1 | Debug halt pulse on trap |
| halt_pc | output | 32 | Trap address |
| vec_err | output | 1 | Unsupported vector pulse |

## Verification
Wrong internal state shows up at the ports one cycle after the request that exposes it. A misclassified vector puts a return address in `epcr_q` that is off by 4. A wrong base choice shows in the top nibble of `redirect_pc`. Stale or corrupted context stays hidden until a later return, which then sends fetch and the status write to the wrong values. For that reason every entry in the bench is followed, sooner or later, by a return that reads the saved context back out through `redirect_pc` and `sr_wr_data`.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned VEC_BUS     = 2;
  localparam int unsigned VEC_TICK    = 5;
  localparam int unsigned VEC_ALIGN   = 6;
  localparam int unsigned VEC_ILLEGAL = 7;
  localparam int unsigned VEC_EXTINT  = 8;
  localparam int unsigned VEC_SYSCALL = 12;
  localparam int unsigned VEC_TRAP    = 14;

  typedef enum logic [1:0] {
    KIND_RET_NEXT = 2'd0,
    KIND_RET_SAME = 2'd1,
    KIND_TRAP     = 2'd2,
    KIND_BAD      = 2'd3
  } exc_kind_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic [VEC_W-1:0] vec_i,
  output exc_kind_t        kind_o,
  output logic             illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    unique case (int'(vec_i))
      VEC_TICK, VEC_EXTINT, VEC_SYSCALL: kind_o = KIND_RET_NEXT;
      VEC_BUS, VEC_ALIGN:                kind_o = KIND_RET_SAME;
      VEC_ILLEGAL: begin
        kind_o    = KIND_RET_SAME;
        illegal_o = 1'b1;
      end
      VEC_TRAP:                          kind_o = KIND_TRAP;
      default:                           kind_o = KIND_BAD;
    endcase
  end
endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned VEC_W      = 5,
  parameter int unsigned VEC_SHIFT  = 8,
  parameter logic [XLEN-1:0] HI_BASE = 32'hF000_0000,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic             in_dslot_i,
  input  logic             ret_next_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             hi_base_i,
  output logic [XLEN-1:0]  ret_addr_o,
  output logic [XLEN-1:0]  handler_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] fwd;
  logic [XLEN-1:0] back;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    fwd        = ret_next_i ? STEP : '0;
    back       = in_dslot_i ? STEP : '0;
    ret_addr_o = pc_i + fwd - back;
    base       = hi_base_i ? HI_BASE : '0;
    offset     = XLEN'(vec_i) << VEC_SHIFT;
    handler_o  = base + offset;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned VEC_W     = 5,
  parameter int unsigned VEC_SHIFT = 8,
  parameter int unsigned EPH_BIT   = 14,
  parameter int unsigned DSX_BIT   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic [XLEN-1:0]  exc_pc,
  input  logic             exc_in_dslot,
  input  logic [XLEN-1:0]  sr_cur,
  input  logic             rfe_req,
  output logic             redirect_valid,
  output logic [XLEN-1:0]  redirect_pc,
  output logic             sr_wr_en,
  output logic [XLEN-1:0]  sr_wr_data,
  output logic             dslot_clr,
  output logic [XLEN-1:0]  epcr_q,
  output logic [XLEN-1:0]  esr_q,
  output logic [XLEN-1:0]  eear_q,
  output logic             halt_req,
  output logic [XLEN-1:0]  halt_pc,
  output logic             vec_err
);
  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  exc_kind_t       kind;
  logic            is_illegal;
  logic [XLEN-1:0] ret_addr;
  logic [XLEN-1:0] handler_addr;

  exc_classify #(.VEC_W(VEC_W)) u_classify (
    .vec_i     (exc_vec),
    .kind_o    (kind),
    .illegal_o (is_illegal)
  );

  exc_addr_calc #(
    .XLEN      (XLEN),
    .VEC_W     (VEC_W),
    .VEC_SHIFT (VEC_SHIFT)
  ) u_addr (
    .pc_i       (exc_pc),
    .in_dslot_i (exc_in_dslot),
    .ret_next_i (kind == KIND_RET_NEXT),
    .vec_i      (exc_vec),
    .hi_base_i  (sr_cur[EPH_BIT]),
    .ret_addr_o (ret_addr),
    .handler_o  (handler_addr)
  );

  logic            take_entry, take_trap, take_bad, take_rfe;
  logic            ctx_en, eear_en, out_en, halt_en;
  logic [XLEN-1:0] sr_entry;
  logic [XLEN-1:0] redirect_pc_d, sr_wr_data_d;

  always_comb begin
    take_entry = exc_req && (kind == KIND_RET_NEXT || kind == KIND_RET_SAME);
    take_trap  = exc_req && (kind == KIND_TRAP);
    take_bad   = exc_req && (kind == KIND_BAD);
    take_rfe   = rfe_req && !exc_req;

    ctx_en  = take_entry;
    eear_en = take_entry && is_illegal;
    out_en  = take_entry || take_rfe;
    halt_en = take_trap;

    sr_entry          = sr_cur;
    sr_entry[DSX_BIT] = exc_in_dslot;

    redirect_pc_d = take_entry ? handler_addr : epcr_q;
    sr_wr_data_d  = take_entry ? sr_entry : esr_q;
  end

  // pulse registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_valid <= 1'b0;
      sr_wr_en       <= 1'b0;
      dslot_clr      <= 1'b0;
      halt_req       <= 1'b0;
      vec_err        <= 1'b0;
    end else begin
      redirect_valid <= out_en;
      sr_wr_en       <= out_en;
      dslot_clr      <= out_en;
      halt_req       <= take_trap;
      vec_err        <= take_bad;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_pc <= '0;
      sr_wr_data  <= '0;
      epcr_q      <= '0;
      esr_q       <= '0;
      eear_q      <= '0;
      halt_pc     <= '0;
    end else begin
      if (out_en) begin
        redirect_pc <= redirect_pc_d;
        sr_wr_data  <= sr_wr_data_d;
      end
      if (ctx_en) begin
        epcr_q <= ret_addr;
        esr_q  <= sr_cur;
      end
      if (eear_en) eear_q  <= exc_pc;
      if (halt_en) halt_pc <= exc_pc;
    end
  end

  // R12: only one kind of response per cycle
  a_r12_one_response: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({redirect_valid, halt_req, vec_err}));

  // R2: an entry lands on a handler-aligned address
  a_r2_handler_aligned: assert property (@(posedge clk) disable iff (!rst_ni)
    take_entry |=> redirect_valid && (redirect_pc[VEC_SHIFT-1:0] == '0));

  // R10: a return goes to the saved return address
  a_r10_rfe_target: assert property (@(posedge clk) disable iff (!rst_ni)
    take_rfe |=> redirect_valid && sr_wr_en && (redirect_pc == $past(epcr_q)));

  // R7: trap halts, carries its PC, leaves context alone
  a_r7_trap_halt: assert property (@(posedge clk) disable iff (!rst_ni)
    take_trap |=> halt_req && (halt_pc == $past(exc_pc)) && !sr_wr_en
                  && $stable(epcr_q) && $stable(esr_q));

  // R9: unsupported vector is quiet apart from the error
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    vec_err |-> !redirect_valid && !sr_wr_en && !dslot_clr
                && $stable(epcr_q) && $stable(esr_q) && $stable(eear_q));

  // R8: illegal instruction captures the effective address
  a_r8_eear_load: assert property (@(posedge clk) disable iff (!rst_ni)
    (take_entry && is_illegal) |=> (eear_q == $past(exc_pc)));
endmodule

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  localparam int unsigned XLEN = 32;
  localparam int unsigned VW   = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            exc_req, exc_in_dslot, rfe_req;
  logic [VW-1:0]   exc_vec;
  logic [XLEN-1:0] exc_pc, sr_cur;
  logic            redirect_valid, sr_wr_en, dslot_clr, halt_req, vec_err;
  logic [XLEN-1:0] redirect_pc, sr_wr_data, epcr_q, esr_q, eear_q, halt_pc;

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec),
    .exc_pc(exc_pc), .exc_in_dslot(exc_in_dslot), .sr_cur(sr_cur),
    .rfe_req(rfe_req), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .dslot_clr(dslot_clr), .epcr_q(epcr_q), .esr_q(esr_q), .eear_q(eear_q),
    .halt_req(halt_req), .halt_pc(halt_pc), .vec_err(vec_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    string           tag;
    logic            rv, we, dc, hr, er;
    logic [XLEN-1:0] rpc, wd, epcr, esr, eear, hpc;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic [XLEN-1:0] m_epcr = 0, m_esr = 0, m_eear = 0, m_rpc = 0, m_wd = 0, m_hpc = 0;

  task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_next(int v);
    return v == 5 || v == 8 || v == 12;
  endfunction
  function automatic bit is_same(int v);
    return v == 2 || v == 6 || v == 7;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(string tag, logic req, int vec, logic [XLEN-1:0] pc,
                      logic ds, logic [XLEN-1:0] sr, logic rfe);
    exp_t e;
    @(negedge clk);
    exc_req = req; exc_vec = VW'(vec); exc_pc = pc; exc_in_dslot = ds;
    sr_cur = sr; rfe_req = rfe;
    e.tag = tag;
    e.rv = 0; e.we = 0; e.dc = 0; e.hr = 0; e.er = 0;
    if (req) begin
      if (is_next(vec) || is_same(vec)) begin
        logic [XLEN-1:0] ra;
        ra = pc + (is_next(vec) ? 4 : 0) - (ds ? 4 : 0);
        e.rv = 1; e.we = 1; e.dc = 1;
        m_rpc = (sr[14] ? 32'hF000_0000 : 32'h0) + (XLEN'(vec) << 8);
        m_wd = sr; m_wd[13] = ds;
        m_epcr = ra; m_esr = sr;
        if (vec == 7) m_eear = pc;
      end else if (vec == 14) begin
        e.hr = 1; m_hpc = pc;
      end else begin
        e.er = 1;
      end
    end else if (rfe) begin
      e.rv = 1; e.we = 1; e.dc = 1;
      m_rpc = m_epcr; m_wd = m_esr;
    end
    e.rpc = m_rpc; e.wd = m_wd; e.epcr = m_epcr; e.esr = m_esr;
    e.eear = m_eear; e.hpc = m_hpc;
    q.push_back(e);
  endtask

  // monitor: compares after each active edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "redirect_valid", XLEN'(redirect_valid), XLEN'(e.rv));
        chk(e.tag, "sr_wr_en",       XLEN'(sr_wr_en),       XLEN'(e.we));
        chk(e.tag, "dslot_clr",      XLEN'(dslot_clr),      XLEN'(e.dc));
        chk(e.tag, "halt_req",       XLEN'(halt_req),       XLEN'(e.hr));
        chk(e.tag, "vec_err",        XLEN'(vec_err),        XLEN'(e.er));
        if (e.rv) chk(e.tag, "redirect_pc", redirect_pc, e.rpc);
        if (e.we) chk(e.tag, "sr_wr_data",  sr_wr_data,  e.wd);
        if (e.hr) chk(e.tag, "halt_pc",     halt_pc,     e.hpc);
        chk(e.tag, "epcr_q", epcr_q, e.epcr);
        chk(e.tag, "esr_q",  esr_q,  e.esr);
        chk(e.tag, "eear_q", eear_q, e.eear);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; exc_req = 0; exc_vec = '0; exc_pc = '0; exc_in_dslot = 0;
    sr_cur = '0; rfe_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    // R1: outputs at reset and first cycle out of it
    chk("R1", "pulses", XLEN'({redirect_valid, sr_wr_en, dslot_clr, halt_req, vec_err}), '0);
    chk("R1", "epcr_q", epcr_q, '0);
    chk("R1", "esr_q",  esr_q,  '0);
    chk("R1", "eear_q", eear_q, '0);
    repeat (2) @(negedge clk);

    step("R12", 0, 0, 32'h0, 0, 32'h0, 0);
    step("R2_R3", 1, 12, 32'h0000_1000, 0, 32'h0000_0001, 0);         // syscall, low base
    step("R6_R10", 0, 0, 32'h0, 0, 32'h0, 1);                         // return
    step("R8_R5", 1, 7, 32'h0000_2000, 0, 32'h0000_4003, 0);          // illegal, high base
    step("R10", 0, 0, 32'h0, 0, 32'h0, 1);
    step("R4", 1, 12, 32'h0000_3004, 1, 32'h0000_0000, 0);            // syscall in delay slot
    step("R4_R5", 1, 6, 32'h0000_4008, 1, 32'h0000_2000, 0);          // align in delay slot
    step("R10", 0, 0, 32'h0, 0, 32'h0, 1);
    step("R3", 1, 5, 32'h0000_5000, 0, 32'h0000_0000, 0);             // tick
    step("R3", 1, 8, 32'h0000_6000, 0, 32'h0000_4000, 0);             // external interrupt
    step("R3_R8", 1, 2, 32'h0000_7000, 0, 32'h0000_0000, 0);          // bus error, eear kept
    step("R7", 1, 14, 32'h0000_8000, 0, 32'h0000_4000, 0);            // trap
    step("R10", 0, 0, 32'h0, 0, 32'h0, 1);                            // context survives trap
    step("R9", 1, 3, 32'h0000_9000, 0, 32'h0000_4000, 0);             // unsupported
    step("R9", 1, 31, 32'h0000_9100, 1, 32'h0000_0000, 0);
    step("R10", 0, 0, 32'h0, 0, 32'h0, 1);                            // context survives error
    step("R11", 1, 12, 32'h0000_A000, 1, 32'h0000_4000, 1);           // entry beats return
    step("R12", 0, 0, 32'h0, 0, 32'h0, 0);
    step("R12", 0, 0, 32'h0, 0, 32'h0, 0);
    step("R10", 0, 0, 32'h0, 0, 32'h0, 1);
    step("R12", 0, 0, 32'h0, 0, 32'h0, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule